// File: doc/BRIEF.md
# Selectable-Period Watchdog with Pulse Output

This block supervises a processor by watching a strobe input. Each qualified high-to-low transition on the strobe restarts a timeout count. If no qualified restart arrives before the selected period runs out, the block drives an active-low watchdog output low for a fixed pulse length. It then releases the output and starts a new period.

The period comes from a 2-bit select field. Three codes pick a period and the fourth code turns the watchdog off. Time is counted in ticks of `TICK_CYCLES` clocks each. At the defaults one tick is one millisecond at 50 MHz, and a bench can shrink the tick to a couple of cycles. The strobe is asynchronous and passes through a two-flop synchroniser. It must then stay low for a minimum number of clocks before it counts as a restart. A backup-mode input stops all timing while it is high, and timing resumes where it left off when the input goes low.

Top module: `wd_pulse_timer`

## Requirements
- R1: While reset is high, and in the cycle after, `wdo_n` is 1. Reset loads the disabled setting into the internal select copy. If `period_sel` shows an enabled code when reset is released, a full period starts at the first clock edge after release.
- R2: Select codes map to periods as follows: 2'b00 gives `LONG_TICKS` (800), 2'b01 gives `MID_TICKS` (400), and 2'b10 gives `SHORT_TICKS` (150). `wdo_n` falls exactly period×`TICK_CYCLES` clock edges after the edge that started the count, provided no restart comes in between.
- R3: Code 2'b11 disables the watchdog, and `wdo_n` stays 1 while it is selected. Moving to 2'b11 during a pulse drives `wdo_n` back to 1 on the next clock edge.
- R4: Once `wdo_n` falls, it stays low for exactly `PULSE_TICKS` (150)×`TICK_CYCLES` unfrozen clock edges and then returns to 1.
- R5: The edge that ends a pulse also starts a fresh full period with the current code.
- R6: A strobe low level that stays low for at least `MIN_LOW_CYCLES` synchronised clocks restarts the count. The restart takes effect `MIN_LOW_CYCLES`+2 edges after the first clock edge that samples the low input.
- R7: A strobe low level shorter than `MIN_LOW_CYCLES` synchronised clocks is ignored, and the timeout keeps its original time.
- R8: When `period_sel` differs from its value at the previous edge, the count restarts from zero with the new period on the next edge. Any pulse in progress ends at that edge.
- R9: While `backup_hold` is 1, the tick and period counts hold, the output holds, and strobe restarts are ignored. Each frozen edge delays the timeout by exactly one edge.
- R10: A qualified strobe restart that arrives during the output pulse changes neither the pulse length nor the following period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| strobe | input | 1 | Asynchronous restart strobe, qualified on a held falling edge |
| period_sel | input | 2 | Period code: 00 long, 01 middle, 10 short, 11 disabled |
| backup_hold | input | 1 | Freezes all timing while high |
| wdo_n | output | 1 | Active-low watchdog pulse output |

## Verification
The assertions treat `period_sel` and `backup_hold` as inputs that are synchronous to the clock. They compare those inputs with their values at the previous edge, and they accept a shortened pulse only when the select code moved during it. Only `strobe` may arrive asynchronously, and no assertion depends on its timing. The bench changes every input on the falling clock edge. It changes the select code only at the start of a scenario or on purpose in the middle of a pulse, so the exact-count checks stay valid.

// File: rtl/wd_pulse_timer.sv
module wd_pulse_timer #(
  parameter int TICK_CYCLES    = 50000,
  parameter int LONG_TICKS     = 800,
  parameter int MID_TICKS      = 400,
  parameter int SHORT_TICKS    = 150,
  parameter int PULSE_TICKS    = 150,
  parameter int MIN_LOW_CYCLES = 20
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       strobe,
  input  logic [1:0] period_sel,
  input  logic       backup_hold,
  output logic       wdo_n
);
  localparam int TW    = (TICK_CYCLES > 1) ? $clog2(TICK_CYCLES) : 1;
  localparam int MAX_A = (LONG_TICKS > MID_TICKS) ? LONG_TICKS : MID_TICKS;
  localparam int MAX_B = (SHORT_TICKS > PULSE_TICKS) ? SHORT_TICKS : PULSE_TICKS;
  localparam int MAXP  = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CW    = $clog2(MAXP + 1);
  localparam int LW    = $clog2(MIN_LOW_CYCLES + 1);
  localparam logic [TW-1:0] T_LAST = TW'(TICK_CYCLES - 1);
  localparam logic [1:0] SEL_OFF = 2'b11;

  typedef enum logic [1:0] {ST_OFF, ST_RUN, ST_PULSE} wd_state_t;

  wd_state_t       state;
  logic            s_meta, s_sync;
  logic [LW-1:0]   low_cnt;
  logic [1:0]      sel_q;
  logic [TW-1:0]   tick_cnt;
  logic [CW-1:0]   t_cnt;
  logic [CW-1:0]   run_last;
  logic            kick, tick, sel_chg;

  always_ff @(posedge clk) begin
    if (rst) begin
      s_meta  <= 1'b1;
      s_sync  <= 1'b1;
      low_cnt <= '0;
    end else begin
      s_meta <= strobe;
      s_sync <= s_meta;
      if (s_sync)
        low_cnt <= '0;
      else if (low_cnt != LW'(MIN_LOW_CYCLES))
        low_cnt <= low_cnt + LW'(1);
    end
  end

  assign kick    = !s_sync && (low_cnt == LW'(MIN_LOW_CYCLES - 1));
  assign tick    = !backup_hold && (tick_cnt == T_LAST);
  assign sel_chg = (period_sel != sel_q);

  always_comb begin
    case (sel_q)
      2'b00:   run_last = CW'(LONG_TICKS - 1);
      2'b01:   run_last = CW'(MID_TICKS - 1);
      2'b10:   run_last = CW'(SHORT_TICKS - 1);
      default: run_last = CW'(LONG_TICKS - 1);
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_OFF;
      sel_q    <= SEL_OFF;
      tick_cnt <= '0;
      t_cnt    <= '0;
      wdo_n    <= 1'b1;
    end else begin
      sel_q <= period_sel;
      if (sel_chg) begin
        tick_cnt <= '0;
        t_cnt    <= '0;
        wdo_n    <= 1'b1;
        state    <= (period_sel == SEL_OFF) ? ST_OFF : ST_RUN;
      end else if (!backup_hold) begin
        tick_cnt <= (tick_cnt == T_LAST) ? '0 : tick_cnt + TW'(1);
        case (state)
          ST_RUN: begin
            if (kick) begin
              tick_cnt <= '0;
              t_cnt    <= '0;
            end else if (tick) begin
              if (t_cnt == run_last) begin
                t_cnt <= '0;
                wdo_n <= 1'b0;
                state <= ST_PULSE;
              end else begin
                t_cnt <= t_cnt + CW'(1);
              end
            end
          end
          ST_PULSE: begin
            if (tick) begin
              if (t_cnt == CW'(PULSE_TICKS - 1)) begin
                t_cnt <= '0;
                wdo_n <= 1'b1;
                state <= ST_RUN;
              end else begin
                t_cnt <= t_cnt + CW'(1);
              end
            end
          end
          default: begin
            tick_cnt <= '0;
            t_cnt    <= '0;
            wdo_n    <= 1'b1;
          end
        endcase
      end
    end
  end
endmodule

module wd_pulse_timer_chk #(
  parameter int TICK_CYCLES = 50000,
  parameter int SHORT_TICKS = 150,
  parameter int PULSE_TICKS = 150
) (
  input logic       clk,
  input logic       rst,
  input logic [1:0] period_sel,
  input logic       backup_hold,
  input logic       wdo_n
);
  localparam int unsigned PULSE_EDGES = PULSE_TICKS * TICK_CYCLES;
  localparam int unsigned MIN_GAP     = SHORT_TICKS * TICK_CYCLES;

  logic        rst_d, wdo_d, abort;
  logic [1:0]  sel_d;
  int unsigned lo_cnt, hi_cnt;

  always_ff @(posedge clk) begin
    rst_d <= rst;
    if (rst) begin
      wdo_d  <= 1'b1;
      sel_d  <= period_sel;
      abort  <= 1'b0;
      lo_cnt <= 0;
      hi_cnt <= 0;
    end else begin
      wdo_d <= wdo_n;
      sel_d <= period_sel;
      if (wdo_n) begin
        lo_cnt <= 0;
        abort  <= 1'b0;
        if (hi_cnt != 32'hFFFF_FFFF) hi_cnt <= hi_cnt + 1;
      end else begin
        hi_cnt <= 0;
        if (!backup_hold) lo_cnt <= lo_cnt + 1;
        if (period_sel != sel_d) abort <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst_d)
      a_r1_reset_inactive: assert (wdo_n) else $error("wdo_n low right after reset");
    if (!rst && wdo_n && !wdo_d && !abort)
      a_r4_pulse_width: assert (lo_cnt == PULSE_EDGES) else $error("pulse length %0d", lo_cnt);
    if (!rst && !wdo_n && wdo_d)
      a_r2_no_early_timeout: assert (hi_cnt >= MIN_GAP) else $error("timeout after %0d", hi_cnt);
  end

  a_r3_disabled_quiet: assert property (@(posedge clk) disable iff (rst)
    (period_sel == 2'b11 && $past(period_sel) == 2'b11) |-> wdo_n);

  a_r9_freeze_hold: assert property (@(posedge clk) disable iff (rst)
    (backup_hold && period_sel == $past(period_sel)) |=> $stable(wdo_n));
endmodule

bind wd_pulse_timer wd_pulse_timer_chk #(
  .TICK_CYCLES(TICK_CYCLES),
  .SHORT_TICKS(SHORT_TICKS),
  .PULSE_TICKS(PULSE_TICKS)
) u_chk (
  .clk(clk),
  .rst(rst),
  .period_sel(period_sel),
  .backup_hold(backup_hold),
  .wdo_n(wdo_n)
);

// File: tb/wd_pulse_timer_test.sv
module wd_pulse_timer_test;
  localparam int T     = 2;
  localparam int ML    = 20;
  localparam int LIMIT = 4000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       strobe = 1'b1;
  logic [1:0] period_sel = 2'b11;
  logic       backup_hold = 1'b0;
  logic       wdo_n;
  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  wd_pulse_timer #(.TICK_CYCLES(T), .MIN_LOW_CYCLES(ML)) uut (
    .clk(clk), .rst(rst), .strobe(strobe), .period_sel(period_sel),
    .backup_hold(backup_hold), .wdo_n(wdo_n)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic do_reset(input logic [1:0] sel);
    @(negedge clk);
    rst = 1'b1; period_sel = sel; strobe = 1'b1; backup_hold = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic measure(input logic lvl, input int kick_at, input int kick_len,
                         input int hold_at, input int hold_len, output int n);
    n = 0;
    forever begin
      @(negedge clk);
      n++;
      if (n == kick_at) strobe = 1'b0;
      if (n == kick_at + kick_len) strobe = 1'b1;
      if (n == hold_at) backup_hold = 1'b1;
      if (n == hold_at + hold_len) backup_hold = 1'b0;
      if (wdo_n == lvl || n >= LIMIT) break;
    end
    strobe = 1'b1;
    backup_hold = 1'b0;
  endtask

  task automatic t_reset_disabled();
    int lows = 0;
    do_reset(2'b11);
    @(negedge clk);
    chk("R1 output after reset", wdo_n, 1);
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      if (!wdo_n) lows++;
    end
    chk("R3 disabled never fires", lows, 0);
  endtask

  task automatic t_reset_enabled();
    int n;
    do_reset(2'b10);
    measure(1'b0, -100, 0, -100, 0, n);
    chk("R1 first period after reset", n, 1 + 150 * T);
    measure(1'b1, -100, 0, -100, 0, n);
    chk("R4 pulse length", n, 150 * T);
    measure(1'b0, -100, 0, -100, 0, n);
    chk("R5 period after pulse", n, 150 * T);
  endtask

  task automatic t_force_off();
    int lows = 0;
    period_sel = 2'b11;
    @(negedge clk);
    chk("R3 disable ends pulse", wdo_n, 1);
    for (int i = 0; i < 500; i++) begin
      @(negedge clk);
      if (!wdo_n) lows++;
    end
    chk("R3 stays quiet", lows, 0);
  endtask

  task automatic t_periods();
    int n;
    period_sel = 2'b00;
    measure(1'b0, -100, 0, -100, 0, n);
    chk("R2 code 00 period", n, 1 + 800 * T);
    period_sel = 2'b01;
    measure(1'b0, -100, 0, -100, 0, n);
    chk("R8 change during pulse, code 01 period", n, 1 + 400 * T);
  endtask

  task automatic t_kick();
    int n;
    period_sel = 2'b10;
    measure(1'b0, 100, ML, -100, 0, n);
    chk("R6 minimum-width restart", n, 100 + ML + 2 + 150 * T);
  endtask

  task automatic t_short();
    int n;
    period_sel = 2'b01;
    measure(1'b0, 50, ML - 1, -100, 0, n);
    chk("R7 short strobe ignored", n, 1 + 400 * T);
  endtask

  task automatic t_freeze();
    int n;
    period_sel = 2'b10;
    measure(1'b0, 55, 30, 50, 60, n);
    chk("R9 freeze delays and blocks restart", n, 1 + 150 * T + 60);
  endtask

  task automatic t_pulse_kick();
    int n;
    measure(1'b1, 1, 25, -100, 0, n);
    chk("R10 pulse length with strobe", n, 150 * T);
    measure(1'b0, -100, 0, -100, 0, n);
    chk("R10 period after strobed pulse", n, 150 * T);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_reset_disabled();
    t_reset_enabled();
    t_force_off();
    t_periods();
    t_kick();
    t_short();
    t_freeze();
    t_pulse_kick();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule